// File: doc/BRIEF.md
# Three-Phase Instruction Sequencer

This block is the control heart of a small non-pipelined processor core. It walks a fixed rotation of fetch, decode and execute, with one phase live at any time. In the fetch phase it reads the instruction one byte per cycle from a byte-wide synchronous memory port, starting at the program counter. It assembles the four bytes most-significant first into a 32-bit word and stores that word together with the address it came from. It then advances the program counter by four.

Once the word is complete, the decoder gets a single-cycle enable. The execute stage gets a single-cycle enable on the following cycle. During that execute cycle the execute stage may hand back a new program counter for a branch. Any of the three stages can report a fault. The sequencer then records a stage-coded error value, stops all activity and holds that value until reset. A halt request stops the sequencer after the current instruction has finished executing. The sequencer stays stopped until reset.

Top module: `insn_phase_sequencer`

## Requirements
- R1: While reset is asserted, `pc` reads 0x00000000, `err_code` reads 0, and `dec_en` and `exe_en` are low.
- R2: `dec_en` and `exe_en` are never high together, and each pulse lasts exactly one cycle. `exe_en` follows a fault-free `dec_en` in the next cycle. A fault-free execute cycle with no halt is followed by a new fetch.
- R3: A fetch issues exactly four reads on `mem_rd`, in consecutive cycles, at `pc`, `pc+1`, `pc+2` and `pc+3`. Read data arrives one cycle after each request. `dec_en` rises in the cycle after the last byte is captured, so a fetch spans five cycles.
- R4: `insn_word` is big-endian. The byte read from `pc` lands in bits 31:24, the byte from `pc+1` in bits 23:16, the byte from `pc+2` in bits 15:8 and the byte from `pc+3` in bits 7:0.
- R5: When `dec_en` is high, `insn_addr` equals the address the word was fetched from and `pc` equals that address plus 4.
- R6: An execute cycle with `exe_branch` high and no fault loads `exe_target` into `pc`, and the next fetch starts at that address.
- R7: `err_code` becomes 3 for `mem_fault` on a captured fetch byte, 2 for `dec_fault` while `dec_en` is high, and 1 for `exe_fault` while `exe_en` is high.
- R8: `exe_sreg_fault` during execute (an out-of-range special-register write) yields `err_code` 4, even when `exe_fault` is high in the same cycle.
- R9: Once `err_code` is nonzero it holds its value until reset. From then on no reads are issued, no enables pulse and `pc` stays unchanged. A branch requested in the faulting cycle is not taken.
- R10: A one-cycle `halt_req` at any point is remembered. The current instruction still decodes and executes, and after that no further reads or enables occur until reset, with `err_code` left at 0.
- R11: When `halt_req` and an execute fault occur in the same cycle, the fault is recorded (`err_code` 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| mem_fault | input | 1 | Fault flag, valid with `mem_rdata` |
| dec_en | output | 1 | One-cycle decode enable |
| insn_word | output | 32 | Assembled instruction word |
| insn_addr | output | 32 | Address the word was fetched from |
| dec_fault | input | 1 | Decoder fault, sampled while `dec_en` is high |
| exe_en | output | 1 | One-cycle execute enable |
| exe_fault | input | 1 | Execute fault, sampled while `exe_en` is high |
| exe_sreg_fault | input | 1 | Out-of-range special-register write, sampled while `exe_en` is high |
| exe_branch | input | 1 | Branch taken, sampled while `exe_en` is high |
| exe_target | input | 32 | Branch destination |
| halt_req | input | 1 | Halt request |
| pc | output | 32 | Program counter |
| err_code | output | 3 | 0 ok, 1 execute, 2 decode, 3 fetch, 4 internal |

## Verification
In the execute cycle, three events can coincide: a branch, a fault and a halt. The bench provokes each combination with a single instruction whose top byte makes the bench's stand-in execute stage raise several responses in the same cycle. One instruction raises branch and fault together, which must leave `pc` at the fetch address plus 4 with code 1. Another raises both fault kinds, which must give code 4. A third raises fault and halt, which must give code 1. A scoreboard of expected fetch addresses and words flags any read or enable that occurs after the freeze.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_HALT   = 3'd3,
        PH_FROZEN = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_EXEC     = 3'd1,
        ERR_DECODE   = 3'd2,
        ERR_FETCH    = 3'd3,
        ERR_INTERNAL = 3'd4
    } err_e;

endpackage

// File: rtl/seq_byte_gather.sv
module seq_byte_gather #(
    parameter int INSN_BYTES = 4,
    parameter int WORD_W     = 8 * INSN_BYTES,
    parameter int CNT_W      = $clog2(INSN_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [7:0]        rdata,
    input  logic              flt,
    output logic              rd,
    output logic [CNT_W-1:0]  off,
    output logic              capture,
    output logic              fin,
    output logic [WORD_W-1:0] word
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INSN_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shift;
        logic [WORD_W-1:0] word;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d   = cur_q;
        rd      = active && (cur_q.cnt != LAST);
        capture = active && (cur_q.cnt != '0);
        fin     = active && (cur_q.cnt == LAST) && !flt;
        if (active) begin
            if (capture) begin
                nxt_d.shift = {cur_q.shift[WORD_W-9:0], rdata};
            end
            if (cur_q.cnt == LAST) begin
                nxt_d.cnt = '0;
                if (!flt) begin
                    nxt_d.word = {cur_q.shift[WORD_W-9:0], rdata};
                end
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign off  = cur_q.cnt;
    assign word = cur_q.word;

    assert_rd_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && cur_q.cnt != '0) |-> $past(rd));

endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin,
    input  logic              take_branch,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] insn_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ia;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (fin) begin
            nxt_d.ia = cur_q.pc;
            nxt_d.pc = cur_q.pc + ADDR_W'(STEP);
        end else if (take_branch) begin
            nxt_d.pc = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pc        = cur_q.pc;
    assign insn_addr = cur_q.ia;

endmodule

// File: rtl/seq_err_latch.sv
module seq_err_latch
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic f_fetch,
    input  logic f_dec,
    input  logic f_exec,
    input  logic f_int,
    output err_e err
);
    err_e err_q, err_d;

    always_comb begin
        err_d = err_q;
        if (err_q == ERR_NONE) begin
            if (f_int) begin
                err_d = ERR_INTERNAL;
            end else if (f_exec) begin
                err_d = ERR_EXEC;
            end else if (f_dec) begin
                err_d = ERR_DECODE;
            end else if (f_fetch) begin
                err_d = ERR_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= ERR_NONE;
        end else begin
            err_q <= err_d;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fin,
    input  logic   fault,
    input  logic   halt_in,
    output phase_e phase
);
    typedef struct packed {
        phase_e ph;
        logic   halt_pend;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.halt_pend = cur_q.halt_pend | halt_in;
        unique case (cur_q.ph)
            PH_FETCH: begin
                if (fault) begin
                    nxt_d.ph = PH_FROZEN;
                end else if (fin) begin
                    nxt_d.ph = PH_DECODE;
                end
            end
            PH_DECODE: begin
                nxt_d.ph = fault ? PH_FROZEN : PH_EXEC;
            end
            PH_EXEC: begin
                if (fault) begin
                    nxt_d.ph = PH_FROZEN;
                end else if (cur_q.halt_pend || halt_in) begin
                    nxt_d.ph = PH_HALT;
                end else begin
                    nxt_d.ph = PH_FETCH;
                end
            end
            default: nxt_d.ph = cur_q.ph;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{ph: PH_FETCH, halt_pend: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign phase = cur_q.ph;

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph == PH_HALT) |=> (cur_q.ph == PH_HALT));

endmodule

// File: rtl/insn_phase_sequencer.sv
module insn_phase_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4,
    parameter int WORD_W     = 8 * INSN_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_fault,
    output logic              dec_en,
    output logic [WORD_W-1:0] insn_word,
    output logic [ADDR_W-1:0] insn_addr,
    input  logic              dec_fault,
    output logic              exe_en,
    input  logic              exe_fault,
    input  logic              exe_sreg_fault,
    input  logic              exe_branch,
    input  logic [ADDR_W-1:0] exe_target,
    input  logic              halt_req,
    output logic [ADDR_W-1:0] pc,
    output logic [2:0]        err_code
);
    localparam int CNT_W = $clog2(INSN_BYTES + 1);

    phase_e           phase;
    err_e             err;
    logic             in_fetch;
    logic             capture;
    logic             fin;
    logic [CNT_W-1:0] off;
    logic             f_fetch, f_dec, f_exec, f_int, fault_any;
    logic             take_branch;

    assign in_fetch    = (phase == PH_FETCH);
    assign dec_en      = (phase == PH_DECODE);
    assign exe_en      = (phase == PH_EXEC);

    assign f_fetch     = capture && mem_fault;
    assign f_dec       = dec_en && dec_fault;
    assign f_exec      = exe_en && exe_fault;
    assign f_int       = exe_en && exe_sreg_fault;
    assign fault_any   = f_fetch | f_dec | f_exec | f_int;
    assign take_branch = exe_en && exe_branch && !exe_fault && !exe_sreg_fault;

    seq_byte_gather #(
        .INSN_BYTES (INSN_BYTES),
        .WORD_W     (WORD_W),
        .CNT_W      (CNT_W)
    ) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_fetch),
        .rdata   (mem_rdata),
        .flt     (mem_fault),
        .rd      (mem_rd),
        .off     (off),
        .capture (capture),
        .fin     (fin),
        .word    (insn_word)
    );

    seq_pc_unit #(
        .ADDR_W (ADDR_W),
        .STEP   (INSN_BYTES)
    ) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .fin         (fin),
        .take_branch (take_branch),
        .target      (exe_target),
        .pc          (pc),
        .insn_addr   (insn_addr)
    );

    seq_err_latch u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .f_fetch (f_fetch),
        .f_dec   (f_dec),
        .f_exec  (f_exec),
        .f_int   (f_int),
        .err     (err)
    );

    seq_phase_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fin     (fin),
        .fault   (fault_any),
        .halt_in (halt_req),
        .phase   (phase)
    );

    assign mem_addr = pc + ADDR_W'(off);
    assign err_code = err;

    assert_dec_to_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !dec_fault) |=> exe_en);

    assert_dec_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> !dec_en);

    assert_fin_to_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> dec_en);

    assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_en) |-> (pc == insn_addr + ADDR_W'(INSN_BYTES)));

    assert_branch_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_en && exe_branch && !exe_fault && !exe_sreg_fault) |=> (pc == $past(exe_target)));

    assert_internal_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_en && exe_sreg_fault) |=> (err_code == 3'd4));

    assert_frozen_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |-> (!mem_rd && !dec_en && !exe_en));

    assert_frozen_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |=> $stable(pc));

endmodule

// File: tb/tb_insn_phase_sequencer.sv
module tb_insn_phase_sequencer;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] word;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_fault = 1'b0;
    logic        dec_en;
    logic [31:0] insn_word;
    logic [31:0] insn_addr;
    logic        dec_fault;
    logic        exe_en;
    logic        exe_fault;
    logic        exe_sreg_fault;
    logic        exe_branch;
    logic [31:0] exe_target;
    logic        halt_req;
    logic [31:0] pc;
    logic [2:0]  err_code;

    logic [7:0]  mem [0:255];
    logic        halt_force = 1'b0;
    logic        fault_en = 1'b0;
    logic [31:0] fault_addr = 32'h0;
    logic [7:0]  op;

    item_t       q[$];
    int          checks = 0;
    int          errors = 0;
    int          rd_n = 0;
    bit          exe_pending = 0;
    bit          exe_expect = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    insn_phase_sequencer dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem_rd         (mem_rd),
        .mem_addr       (mem_addr),
        .mem_rdata      (mem_rdata),
        .mem_fault      (mem_fault),
        .dec_en         (dec_en),
        .insn_word      (insn_word),
        .insn_addr      (insn_addr),
        .dec_fault      (dec_fault),
        .exe_en         (exe_en),
        .exe_fault      (exe_fault),
        .exe_sreg_fault (exe_sreg_fault),
        .exe_branch     (exe_branch),
        .exe_target     (exe_target),
        .halt_req       (halt_req),
        .pc             (pc),
        .err_code       (err_code)
    );

    // stand-in decode/execute stages keyed on the top opcode byte
    assign op             = insn_word[31:24];
    assign dec_fault      = dec_en && (op == 8'hDD);
    assign exe_fault      = exe_en && (op == 8'hEE || op == 8'hEB || op == 8'hEC || op == 8'hFE);
    assign exe_sreg_fault = exe_en && (op == 8'hEC);
    assign exe_branch     = exe_en && (op == 8'hB0 || op == 8'hEB);
    assign exe_target     = {8'h00, insn_word[23:0]};
    assign halt_req       = halt_force | (exe_en && (op == 8'hF0 || op == 8'hFE));

    // synchronous byte memory, one cycle of latency
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[7:0]];
            mem_fault <= fault_en && (mem_addr == fault_addr);
        end else begin
            mem_fault <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [7:0] a, input logic [31:0] w);
        mem[a]      = w[31:24];
        mem[a + 1]  = w[23:16];
        mem[a + 2]  = w[15:8];
        mem[a + 3]  = w[7:0];
    endtask

    // driver: pushes the expected fetch (address and big-endian word)
    task automatic expect_at(input logic [7:0] a);
        item_t it;
        it.addr = {24'h0, a};
        it.word = {mem[a], mem[a + 1], mem[a + 2], mem[a + 3]};
        q.push_back(it);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic start();
        rst_n      = 1'b0;
        halt_force = 1'b0;
        fault_en   = 1'b0;
        repeat (3) @(negedge clk);
        chk(pc == 32'h0, "R1 pc", pc, 32'h0);
        chk(err_code == 3'd0, "R1 err", {29'h0, err_code}, 32'h0);
        chk(!dec_en && !exe_en, "R1 enables", {30'h0, dec_en, exe_en}, 32'h0);
        @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic finish_case(input string req, input logic [2:0] exp_err,
                               input logic [31:0] exp_pc, input int exp_left);
        repeat (60) @(negedge clk);
        chk(err_code == exp_err, {req, " err_code"}, {29'h0, err_code}, {29'h0, exp_err});
        chk(pc == exp_pc, {req, " pc"}, pc, exp_pc);
        chk(q.size() == exp_left, {req, " scoreboard"}, q.size(), exp_left);
        chk(!mem_rd && !dec_en && !exe_en, {req, " idle"}, {29'h0, mem_rd, dec_en, exe_en}, 32'h0);
    endtask

    // monitor: pops the scoreboard on decode and checks every read address
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_n        = 0;
            exe_pending = 0;
            q.delete();
        end else begin
            if (exe_pending) begin
                chk(exe_en == exe_expect, "R2 exe follows dec", {31'h0, exe_en}, {31'h0, exe_expect});
                exe_pending = 0;
            end else if (exe_en) begin
                chk(0, "R2 stray exe_en", 32'h1, 32'h0);
            end
            if (mem_rd) begin
                if (q.size() == 0) begin
                    chk(0, "R9 R10 read after stop", mem_addr, 32'hFFFFFFFF);
                end else begin
                    chk(mem_addr == q[0].addr + rd_n, "R3 read address", mem_addr, q[0].addr + rd_n);
                end
                rd_n++;
            end
            if (dec_en) begin
                if (q.size() == 0) begin
                    chk(0, "R9 R10 decode after stop", insn_addr, 32'hFFFFFFFF);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    chk(insn_word == it.word, "R4 word", insn_word, it.word);
                    chk(insn_addr == it.addr, "R5 insn_addr", insn_addr, it.addr);
                    chk(pc == it.addr + 32'd4, "R5 pc step", pc, it.addr + 32'd4);
                    chk(rd_n == 4, "R3 read count", rd_n, 32'd4);
                    exe_pending = 1;
                    exe_expect  = (it.word[31:24] != 8'hDD);
                end
                rd_n = 0;
            end
        end
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // sequential run, branch, halting instruction (R2 R3 R4 R5 R6 R10)
        clear_mem();
        put_word(8'h00, 32'h12345678);
        put_word(8'h04, 32'h9ABCDEF0);
        put_word(8'h08, 32'hB0000040);
        put_word(8'h40, 32'hF0A55A0F);
        start();
        expect_at(8'h00); expect_at(8'h04); expect_at(8'h08); expect_at(8'h40);
        finish_case("R6 R10 branch then halt", 3'd0, 32'h44, 0);

        // fetch fault on the third byte (R7 R9)
        clear_mem();
        put_word(8'h00, 32'h01020304);
        start();
        fault_en = 1'b1; fault_addr = 32'h2;
        expect_at(8'h00);
        finish_case("R7 fetch fault", 3'd3, 32'h0, 1);

        // decode fault (R7 R9)
        clear_mem();
        put_word(8'h00, 32'hDD000000);
        start();
        expect_at(8'h00);
        finish_case("R7 decode fault", 3'd2, 32'h4, 0);

        // execute fault with a branch in the same cycle (R7 R9)
        clear_mem();
        put_word(8'h00, 32'h33445566);
        put_word(8'h04, 32'hEB000080);
        start();
        expect_at(8'h00); expect_at(8'h04);
        finish_case("R7 R9 exec fault with branch", 3'd1, 32'h8, 0);

        // both fault kinds together (R8)
        clear_mem();
        put_word(8'h00, 32'hEC000000);
        start();
        expect_at(8'h00);
        finish_case("R8 internal fault", 3'd4, 32'h4, 0);

        // halt pulse during fetch takes effect after execute (R10)
        clear_mem();
        put_word(8'h00, 32'h11223344);
        put_word(8'h04, 32'h55667788);
        start();
        expect_at(8'h00);
        @(negedge clk); halt_force = 1'b1;
        @(negedge clk); halt_force = 1'b0;
        finish_case("R10 pending halt", 3'd0, 32'h4, 0);

        // halt and execute fault in the same cycle (R11)
        clear_mem();
        put_word(8'h00, 32'hFE000010);
        start();
        expect_at(8'h00);
        finish_case("R11 fault beats halt", 3'd1, 32'h4, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule